// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus, placed in front of a 256-byte array. It oversamples the clock and data lines with the system clock and finds START and STOP conditions. It takes in the 7-bit device identifier and the direction bit, and acknowledges the bytes addressed to it. Write transfers store bytes in a page of 16 entries and wrap inside that page. Read transfers return bytes from an internal pointer. A read can continue from where the last access left off, start at an explicitly loaded address, or run on for several bytes while the master keeps acknowledging.

The slave also answers two further identifiers that belong to register spaces outside this array. Their written bytes are acknowledged and dropped. Touching either one locks out pointer-relative reads until the master performs an addressed (random) read. The data line is only ever pulled low, through `sda_oe`. The bus itself is the wired-AND of that pull-down and the master's drive, fed back on `sda_in`.

Top module: `ee_serial_slave`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `sda_oe` is low. After reset the read pointer counts as uninitialised.
- R2: A first byte of 1010000 followed by a direction bit is acknowledged by pulling SDA low on the ninth clock. Any identifier other than 1010000, 1010111 or 1010010 gets no acknowledge, and the transfer has no effect.
- R3: In a write (direction bit 0), the byte after the identifier loads the pointer. Each later byte is stored at the pointer and acknowledged. The pointer then advances only in its low 4 bits, so it wraps inside its 16-byte page: 12 bytes from address 11 land at 11..15 and then 0..6, and the pointer is left at 7.
- R4: A write of the identifier and an address byte, followed by a repeated START and the identifier with direction bit 1, returns the byte at the loaded address, MSB first.
- R5: While the master acknowledges each read byte, the slave sends the following address. In reads the pointer counts over all 8 bits and rolls from 255 to 0.
- R6: A read that starts without an address byte returns the byte at the last accessed address plus one. After a page-wrapping write, that is the wrapped pointer.
- R7: A read without an address byte, made before any address byte has been loaded since reset, is not acknowledged.
- R8: Identifiers 1010111 and 1010010 are acknowledged. Their written bytes are acknowledged and leave the array unchanged, and their reads return all ones. After such an access, a read without an address byte is not acknowledged. This lasts until a random read (R4) is accepted, which lifts the lock.
- R9: When the master leaves SDA high on the ninth clock of a read byte, the slave releases SDA. It drives nothing until the next START.
- R10: A STOP or START received mid-byte ends the transfer. The partial byte is not written, and SDA is released.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Serial clock from the master |
| sda_in | input | 1 | Sampled level of the shared data line |
| sda_oe | output | 1 | Pulls the data line low when high |

## Verification
A wrong pointer shows up as a wrong byte on the very next read that has no address byte. A missed page wrap corrupts a neighbouring page, and this is only seen when that page is read back, so the bench fills the whole array and rereads it at random. A stuck lock flag or init flag shows up at once as a missing acknowledge on the ninth clock of the identifier byte. An acknowledge or data bit driven at the wrong moment shows up as a data-line change while SCL is high, which the bus would take as a false START or STOP.

// File: rtl/ee_slave_pkg.sv
package ee_slave_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int BIT_N  = 8;

    localparam logic [6:0] MEM_ID   = 7'b1010000;
    localparam logic [6:0] REG_ID_A = 7'b1010111;
    localparam logic [6:0] REG_ID_B = 7'b1010010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } ee_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    // advance an address inside its page of 2**pw entries
    function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a,
                                                    input int unsigned pw);
        logic [ADDR_W-1:0] m;
        m = ADDR_W'((1 << pw) - 1);
        return (a & ~m) | ((a + 1'b1) & m);
    endfunction

endpackage

// File: rtl/ee_bus_sampler.sv
module ee_bus_sampler
    import ee_slave_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda_in,
    output bus_evt_t evt
);
    // index 0 holds the newest sample, index 1 the one before
    logic [1:0] scl_q;
    logic [1:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 2'b11;
            sda_q <= 2'b11;
        end else begin
            scl_q <= {scl_q[0], scl};
            sda_q <= {sda_q[0], sda_in};
        end
    end

    always_comb begin
        evt.rise  = scl_q[0] & ~scl_q[1];
        evt.fall  = ~scl_q[0] & scl_q[1];
        evt.start = &scl_q & sda_q[1] & ~sda_q[0];
        evt.stop  = &scl_q & ~sda_q[1] & sda_q[0];
        evt.sda   = sda_q[0];
    end
endmodule

// File: rtl/ee_regfile.sv
module ee_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ee_slave_fsm.sv
module ee_slave_fsm
    import ee_slave_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [DATA_W-1:0] rdata,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] ptr
);
    localparam int CNT_W = $clog2(BIT_N + 1);

    ee_state_e          st, st_ret;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-1:0]  sh;
    logic               ptr_ok;   // pointer loaded since reset
    logic               fresh;    // address byte just loaded, no data yet
    logic               locked;   // register space touched, pointer reads barred
    logic               other;    // current transfer targets a register space
    logic [6:0]         dev_id;
    logic               dev_rd;
    logic [DATA_W-1:0]  tx;

    assign dev_id = sh[DATA_W-1:1];
    assign dev_rd = sh[0];
    assign tx     = other ? '1 : rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            st_ret    <= ST_IDLE;
            cnt       <= '0;
            sh        <= '0;
            ptr       <= '0;
            ptr_ok    <= 1'b0;
            fresh     <= 1'b0;
            locked    <= 1'b0;
            other     <= 1'b0;
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (evt.start) begin
                st     <= ST_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
                fresh  <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (evt.rise && cnt != CNT_W'(BIT_N)) begin
                            sh  <= {sh[DATA_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.fall && cnt == CNT_W'(BIT_N)) begin
                            cnt    <= '0;
                            st     <= ST_ACK;
                            sda_oe <= 1'b1;
                            if (st == ST_DEV) begin
                                if (dev_id == MEM_ID && !dev_rd) begin
                                    other  <= 1'b0;
                                    st_ret <= ST_WADDR;
                                end else if (dev_id == MEM_ID && (fresh || (ptr_ok && !locked))) begin
                                    other  <= 1'b0;
                                    st_ret <= ST_RDATA;
                                    fresh  <= 1'b0;
                                    if (fresh) locked <= 1'b0;
                                end else if (dev_id == REG_ID_A || dev_id == REG_ID_B) begin
                                    other  <= 1'b1;
                                    locked <= 1'b1;
                                    fresh  <= 1'b0;
                                    st_ret <= dev_rd ? ST_RDATA : ST_WDATA;
                                end else begin
                                    st     <= ST_IGNORE;
                                    sda_oe <= 1'b0;
                                end
                            end else if (st == ST_WADDR) begin
                                ptr    <= sh;
                                ptr_ok <= 1'b1;
                                fresh  <= 1'b1;
                                st_ret <= ST_WDATA;
                            end else begin
                                fresh  <= 1'b0;
                                st_ret <= ST_WDATA;
                                if (!other) begin
                                    mem_we    <= 1'b1;
                                    mem_waddr <= ptr;
                                    mem_wdata <= sh;
                                    ptr       <= page_next(ptr, PAGE_W);
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.fall) begin
                            st  <= st_ret;
                            cnt <= '0;
                            if (st_ret == ST_RDATA) begin
                                sh     <= tx;
                                sda_oe <= ~tx[DATA_W-1];
                                if (!other) ptr <= ptr + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (evt.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.fall) begin
                            if (cnt == CNT_W'(BIT_N)) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                st     <= ST_RACK;
                            end else begin
                                sda_oe <= ~sh[DATA_W-2];
                                sh     <= {sh[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.rise) begin
                            if (evt.sda) begin
                                st <= ST_IGNORE;
                            end else begin
                                st     <= ST_ACK;
                                st_ret <= ST_RDATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ee_serial_slave.sv
module ee_serial_slave
    import ee_slave_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda_in,
    output logic sda_oe
);
    bus_evt_t          evt;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] rd_ptr;
    logic [DATA_W-1:0] rdata;

    ee_bus_sampler u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl    (scl),
        .sda_in (sda_in),
        .evt    (evt)
    );

    ee_slave_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .rdata     (rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .ptr       (rd_ptr)
    );

    ee_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_ptr),
        .rdata (rdata)
    );
endmodule

// File: rtl/ee_serial_slave_chk.sv
module ee_serial_slave_chk
    import ee_slave_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              scl,
    input logic              sda_oe,
    input logic              stop_evt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [ADDR_W-1:0] ptr
);
    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sda_oe);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    // R3
    page_keep_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((ptr >> PAGE_W) == (mem_waddr >> PAGE_W)));

    // R3
    page_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (ptr[PAGE_W-1:0] == PAGE_W'(mem_waddr[PAGE_W-1:0] + 1'b1)));
endmodule

bind ee_serial_slave ee_serial_slave_chk #(.PAGE_W(PAGE_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .scl       (scl),
    .sda_oe    (sda_oe),
    .stop_evt  (evt.stop),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .ptr       (rd_ptr)
);

// File: tb/test_ee_serial_slave.sv
`timescale 1ns/1ps
module test_ee_serial_slave;
    localparam int T = 4;
    localparam logic [6:0] MEM  = 7'b1010000;
    localparam logic [6:0] RGA  = 7'b1010111;
    localparam logic [6:0] RGB  = 7'b1010010;
    localparam logic [6:0] BAD  = 7'b1011000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    wire  sda_in = ~(m_low | sda_oe);

    int nchk = 0;
    int nfail = 0;
    int r11_bad = 0;

    logic [7:0] mmem [256];
    logic [7:0] mptr = 8'd0;
    bit mvalid = 1'b0;
    bit mlock = 1'b0;
    logic [7:0] dbuf [16];

    always #4 clk = ~clk;

    ee_serial_slave i_ee_serial_slave (
        .clk(clk), .rst(rst), .scl(scl), .sda_in(sda_in), .sda_oe(sda_oe)
    );

    logic oe_d = 1'b0;
    always @(posedge clk) begin
        #1;
        if (!rst && oe_d !== sda_oe && scl) r11_bad++;
        oe_d = sda_oe;
    end

    function automatic logic [7:0] wnext(input logic [7:0] a);
        return {a[7:4], a[3:0] + 4'd1};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(T);
        scl = 1'b1;   tick(T);
        m_low = 1'b1; tick(T);
        scl = 1'b0;   tick(T);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(T);
        scl = 1'b1;   tick(T);
        m_low = 1'b0; tick(T);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; tick(T);
        scl = 1'b1; tick(T);
        scl = 1'b0; tick(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; tick(T);
        scl = 1'b1; tick(2);
        acked = ~sda_in;
        tick(T - 2);
        scl = 1'b0; tick(T);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(T);
            scl = 1'b1; tick(2);
            d[i] = sda_in;
            tick(T - 2);
            scl = 1'b0;
        end
        tick(T);
        m_low = mack; tick(T);
        scl = 1'b1; tick(T);
        scl = 1'b0; tick(T);
        m_low = 1'b0;
    endtask

    task automatic mem_write(input logic [7:0] a, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte({MEM, 1'b0}, ack); check({tag, " id ack"}, ack, 1'b1);
        send_byte(a, ack);           check({tag, " addr ack"}, ack, 1'b1);
        mptr = a; mvalid = 1'b1;
        for (int i = 0; i < n; i++) begin
            send_byte(dbuf[i], ack); check({tag, " data ack"}, ack, 1'b1);
            mmem[mptr] = dbuf[i];
            mptr = wnext(mptr);
        end
        bus_stop();
    endtask

    task automatic read_out(input int n, input string tag);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            check({tag, " data"}, d, mmem[mptr]);
            mptr = mptr + 8'd1;
        end
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte({MEM, 1'b0}, ack); check({tag, " id ack"}, ack, 1'b1);
        send_byte(a, ack);           check({tag, " addr ack"}, ack, 1'b1);
        bus_start();
        send_byte({MEM, 1'b1}, ack); check({tag, " rd ack"}, ack, 1'b1);
        mptr = a; mvalid = 1'b1; mlock = 1'b0;
        read_out(n, tag);
        bus_stop();
    endtask

    task automatic cur_read(input int n, input string tag);
        logic ack;
        logic exp;
        exp = mvalid && !mlock;
        bus_start();
        send_byte({MEM, 1'b1}, ack); check({tag, " rd ack"}, ack, exp);
        if (ack) read_out(n, tag);
        bus_stop();
    endtask

    task automatic reg_write(input logic [6:0] id, input int n);
        logic ack;
        bus_start();
        send_byte({id, 1'b0}, ack); check("R8 reg id ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(8'($urandom), ack); check("R8 reg data ack", ack, 1'b1);
        end
        mlock = 1'b1;
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int bad;
        void'($urandom(32'h5eed_1234));
        tick(5);
        check("R1 oe in reset", sda_oe, 1'b0);
        rst = 1'b0;
        tick(2);
        check("R1 oe after reset", sda_oe, 1'b0);

        // R7: no address loaded yet
        cur_read(1, "R7");

        // R2: foreign identifier ignored
        bus_start();
        send_byte({BAD, 1'b0}, ack); check("R2 foreign nack", ack, 1'b0);
        bus_stop();

        // R3: fill every page
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < 16; i++) dbuf[i] = 8'($urandom);
            mem_write(8'(p * 16), 16, "R3 fill");
        end
        cur_read(2, "R6 after fill");

        // R3: 12 bytes from 11 wrap in page 0, pointer ends at 7
        for (int i = 0; i < 12; i++) dbuf[i] = 8'($urandom);
        mem_write(8'd11, 12, "R3 wrap");
        cur_read(1, "R6 wrapped ptr");
        rand_read(8'd11, 5, "R4 page tail");
        rand_read(8'd0, 8, "R4 page head");

        // R5: rollover across the top
        rand_read(8'd253, 6, "R5 rollover");
        cur_read(2, "R6 after seq");

        // R8: register space locks pointer reads
        reg_write(RGA, 2);
        cur_read(1, "R8 locked");
        bus_start();
        send_byte({RGB, 1'b1}, ack); check("R8 reg rd ack", ack, 1'b1);
        recv_byte(1'b0, d);          check("R8 reg rd ones", d, 8'hFF);
        bus_stop();
        cur_read(1, "R8 still locked");
        rand_read(8'd40, 1, "R8 unlock");
        cur_read(2, "R8 reopened");

        // R10: STOP mid-byte drops partial data
        bus_start();
        send_byte({MEM, 1'b0}, ack); check("R10 id ack", ack, 1'b1);
        send_byte(8'd100, ack);      check("R10 addr ack", ack, 1'b1);
        mptr = 8'd100;
        for (int i = 0; i < 4; i++) send_bit(~mmem[100][7 - i]);
        bus_stop();
        check("R10 oe released", sda_oe, 1'b0);
        rand_read(8'd100, 1, "R10 unchanged");

        // R9: master nack ends the read
        rand_read(8'd77, 1, "R9 last byte");
        bus_start();
        send_byte({MEM, 1'b1}, ack); check("R9 rd ack", ack, 1'b1);
        recv_byte(1'b0, d);          check("R9 data", d, mmem[mptr]);
        mptr = mptr + 8'd1;
        bad = 0;
        for (int i = 0; i < 9; i++) begin
            tick(T); scl = 1'b1; tick(2);
            if (sda_in !== 1'b1) bad++;
            tick(T - 2); scl = 1'b0;
        end
        tick(T);
        check("R9 line released", bad, 0);
        bus_stop();

        // mixed random traffic
        for (int it = 0; it < 24; it++) begin
            int op;
            int n;
            logic [7:0] a;
            op = $urandom_range(0, 3);
            a  = 8'($urandom);
            if (op == 0) begin
                n = $urandom_range(1, 16);
                for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
                mem_write(a, n, "R3 rnd");
            end else if (op == 1) begin
                rand_read(a, $urandom_range(1, 6), "R5 rnd");
            end else if (op == 2) begin
                cur_read($urandom_range(1, 4), "R6 rnd");
            end else begin
                reg_write(($urandom_range(0, 1) != 0) ? RGA : RGB, $urandom_range(0, 2));
            end
        end

        check("R11 oe only with scl low", r11_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule